// File: doc/BRIEF.md
# Serial Frame Timing Generator

This block paces the transmit side of a synchronous serial link to a codec. It counts serial-clock periods in frames of fixed length, and frames follow one another with no idle clocks between them. During the final clock of every frame it raises a one-clock sync pulse, which tells the far end that a new frame starts on the next clock. In that same sync clock it takes the words offered by three transmit queues: an audio word, a telecom word and a control word. It pops every queue that reports valid data and builds a frame image. Starting on the clock after the sync, it shifts that image out one bit per clock, most significant bit first.

The bit order of a frame is fixed. Bit positions 0 to 15 carry the audio word, positions 16 to 31 the telecom word and positions 32 to 63 the control word, each with its most significant bit first. Positions 64 to 127 are padding, and the line stays low there. A queue that is empty at load time gives zeros in its field. While the enable input is low, the block holds its outputs low and waits with its counter at zero. After enable rises, the first 128 clocks carry no payload, because no sync has happened yet to load data.

Top module: `sframe_gen`

## Requirements
- R1: With enable held high, `fsync_o` goes high in the 128th clock after enable rises and then once in every 128 clocks after that. Enabled clocks are numbered 0, 1, 2 and so on, and the pulse falls in clocks 127, 255, 383 and so on.
- R2: `fsync_o` is never high for two clocks in a row, and successive frames follow each other with no idle clocks between them.
- R3: The words present during a sync clock are sent in the 128 clocks that follow it. In frame position p (0 for the clock after the sync), `txd_o` carries audio bit 15-p for p from 0 to 15, telecom bit 31-p for p from 16 to 31, and control bit 63-p for p from 32 to 63.
- R4: `txd_o` is low in frame positions 64 to 127, and it is low throughout the 128 clocks that follow enable rising.
- R5: If a queue's valid flag is low in the sync clock, its field is sent as all zeros and its pop strobe stays low.
- R6: A pop strobe is high only during a sync clock in which the matching valid flag is high. It is high for exactly that one clock.
- R7: `frm_start_o` is high in the first clock after each sync pulse, which is frame position 0, and low in every other clock.
- R8: While `en_i` is low, `fsync_o`, `txd_o`, `frm_start_o` and all pop strobes are low. Any frame in progress is dropped, and the next enabled clock counts again as clock 0 under R1.
- R9: While `rst_n` is low, and until enable is first raised after reset, all outputs are low. Reset takes effect at once but is released on the clock, two edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Link enable |
| aud_word_i | input | AUD_W (16) | Head of the audio transmit queue |
| tel_word_i | input | TEL_W (16) | Head of the telecom transmit queue |
| ctl_word_i | input | CTL_W (32) | Head of the control transmit queue |
| aud_vld_i | input | 1 | Audio queue not empty |
| tel_vld_i | input | 1 | Telecom queue not empty |
| ctl_vld_i | input | 1 | Control queue not empty |
| fsync_o | output | 1 | Frame sync, high in the last clock of a frame |
| txd_o | output | 1 | Serial transmit data |
| frm_start_o | output | 1 | High in the first clock of a loaded frame |
| aud_pop_o | output | 1 | Pop strobe for the audio queue |
| tel_pop_o | output | 1 | Pop strobe for the telecom queue |
| ctl_pop_o | output | 1 | Pop strobe for the control queue |

## Verification
The assertions assume three things about the inputs. `en_i` changes only between clock edges. `rst_n` is released while `en_i` is low. Enable stays low for at least the two clocks that the internal reset takes to release. The stimulus keeps within these limits: it changes every input half a clock away from the rising edge, it holds enable low through reset and for several clocks after, and it drops enable only rarely and at random points in a frame. The words and valid flags are random on every clock, so each sync clock loads a new mix of full and empty queues. The directed frames cover the extreme cases: all queues full, all queues empty, and enable dropped in the middle of a frame.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam int unsigned DEF_FRAME_LEN = 128;
  localparam int unsigned DEF_AUD_W     = 16;
  localparam int unsigned DEF_TEL_W     = 16;
  localparam int unsigned DEF_CTL_W     = 32;
  localparam int unsigned NUM_CH        = 3;

  typedef enum logic [1:0] {
    CH_AUD = 2'd0,
    CH_TEL = 2'd1,
    CH_CTL = 2'd2
  } sfg_ch_e;
endpackage

// File: rtl/sfg_rst_sync.sv
module sfg_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= stage_d;
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/sfg_frame_ctr.sv
module sfg_frame_ctr #(
  parameter int unsigned FRAME_LEN = sfg_pkg::DEF_FRAME_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic fsync_o,
  output logic start_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign fsync_o = en_i & at_last;
  assign start_o = en_i & start_q;

  always_comb begin
    cnt_d   = cnt_q;
    start_d = 1'b0;
    if (!en_i) begin
      cnt_d = '0;
    end else begin
      start_d = at_last;
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end
endmodule

// File: rtl/sfg_load_mux.sv
module sfg_load_mux #(
  parameter int unsigned FRAME_LEN = sfg_pkg::DEF_FRAME_LEN,
  parameter int unsigned AUD_W     = sfg_pkg::DEF_AUD_W,
  parameter int unsigned TEL_W     = sfg_pkg::DEF_TEL_W,
  parameter int unsigned CTL_W     = sfg_pkg::DEF_CTL_W
) (
  input  logic                                 load_i,
  input  logic [AUD_W-1:0]                     aud_word_i,
  input  logic [TEL_W-1:0]                     tel_word_i,
  input  logic [CTL_W-1:0]                     ctl_word_i,
  input  logic [sfg_pkg::NUM_CH-1:0]           vld_i,
  output logic [sfg_pkg::NUM_CH-1:0]           pop_o,
  output logic [FRAME_LEN-1:0]                 image_o
);
  import sfg_pkg::*;

  localparam int unsigned PAY_W = AUD_W + TEL_W + CTL_W;
  localparam int unsigned PAD_W = FRAME_LEN - PAY_W;

  logic [AUD_W-1:0] aud_m;
  logic [TEL_W-1:0] tel_m;
  logic [CTL_W-1:0] ctl_m;
  logic [PAY_W-1:0] payload;

  assign aud_m   = vld_i[CH_AUD] ? aud_word_i : '0;
  assign tel_m   = vld_i[CH_TEL] ? tel_word_i : '0;
  assign ctl_m   = vld_i[CH_CTL] ? ctl_word_i : '0;
  assign payload = {aud_m, tel_m, ctl_m};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pop
    assign pop_o[ch] = load_i & vld_i[ch];
  end

  if (PAD_W > 0) begin : g_pad
    assign image_o = {payload, {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign image_o = payload[PAY_W-1 -: FRAME_LEN];
  end
endmodule

// File: rtl/sfg_tx_shift.sv
module sfg_tx_shift #(
  parameter int unsigned FRAME_LEN = sfg_pkg::DEF_FRAME_LEN
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 load_i,
  input  logic [FRAME_LEN-1:0] image_i,
  output logic                 txd_o
);
  logic [FRAME_LEN-1:0] sr_q, sr_d;

  always_comb begin
    if (!en_i)       sr_d = '0;
    else if (load_i) sr_d = image_i;
    else             sr_d = {sr_q[FRAME_LEN-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign txd_o = en_i & sr_q[FRAME_LEN-1];
endmodule

// File: rtl/sframe_gen.sv
module sframe_gen #(
  parameter int unsigned FRAME_LEN = sfg_pkg::DEF_FRAME_LEN,
  parameter int unsigned AUD_W     = sfg_pkg::DEF_AUD_W,
  parameter int unsigned TEL_W     = sfg_pkg::DEF_TEL_W,
  parameter int unsigned CTL_W     = sfg_pkg::DEF_CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [AUD_W-1:0] aud_word_i,
  input  logic [TEL_W-1:0] tel_word_i,
  input  logic [CTL_W-1:0] ctl_word_i,
  input  logic             aud_vld_i,
  input  logic             tel_vld_i,
  input  logic             ctl_vld_i,
  output logic             fsync_o,
  output logic             txd_o,
  output logic             frm_start_o,
  output logic             aud_pop_o,
  output logic             tel_pop_o,
  output logic             ctl_pop_o
);
  import sfg_pkg::*;

  logic                 rst_sync_n;
  logic                 fsync;
  logic [NUM_CH-1:0]    vld, pop;
  logic [FRAME_LEN-1:0] image;

  assign vld[CH_AUD] = aud_vld_i;
  assign vld[CH_TEL] = tel_vld_i;
  assign vld[CH_CTL] = ctl_vld_i;

  sfg_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  sfg_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_i    (en_i),
    .fsync_o (fsync),
    .start_o (frm_start_o)
  );

  sfg_load_mux #(
    .FRAME_LEN (FRAME_LEN),
    .AUD_W     (AUD_W),
    .TEL_W     (TEL_W),
    .CTL_W     (CTL_W)
  ) u_mux (
    .load_i     (fsync),
    .aud_word_i (aud_word_i),
    .tel_word_i (tel_word_i),
    .ctl_word_i (ctl_word_i),
    .vld_i      (vld),
    .pop_o      (pop),
    .image_o    (image)
  );

  sfg_tx_shift #(.FRAME_LEN(FRAME_LEN)) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_i    (en_i),
    .load_i  (fsync),
    .image_i (image),
    .txd_o   (txd_o)
  );

  assign fsync_o   = fsync;
  assign aud_pop_o = pop[CH_AUD];
  assign tel_pop_o = pop[CH_TEL];
  assign ctl_pop_o = pop[CH_CTL];
endmodule

// File: rtl/sfg_checker.sv
module sfg_checker #(
  parameter int unsigned FRAME_LEN = 128,
  parameter int unsigned PAY_W     = 64
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic aud_vld_i,
  input logic tel_vld_i,
  input logic ctl_vld_i,
  input logic fsync_o,
  input logic txd_o,
  input logic frm_start_o,
  input logic aud_pop_o,
  input logic tel_pop_o,
  input logic ctl_pop_o
);
  localparam int unsigned GW = $clog2(FRAME_LEN);
  localparam logic [GW-1:0] GLAST = GW'(FRAME_LEN - 1);
  localparam logic [GW-1:0] GPAY  = GW'(PAY_W);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gap_q <= '0;
    else if (!en_i)    gap_q <= '0;
    else if (fsync_o)  gap_q <= '0;
    else               gap_q <= gap_q + 1'b1;
  end

  assert_sync_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |-> (gap_q == GLAST));

  assert_sync_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |=> !fsync_o);

  assert_pad_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txd_o |-> (gap_q < GPAY));

  assert_empty_no_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !((aud_pop_o && !aud_vld_i) || (tel_pop_o && !tel_vld_i) || (ctl_pop_o && !ctl_vld_i)));

  assert_pop_in_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (aud_pop_o || tel_pop_o || ctl_pop_o) |-> fsync_o);

  assert_start_after_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_o |=> (frm_start_o == en_i));

  assert_start_not_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start_o |-> !fsync_o);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !(fsync_o || txd_o || frm_start_o || aud_pop_o || tel_pop_o || ctl_pop_o));
endmodule

bind sframe_gen sfg_checker #(
  .FRAME_LEN (FRAME_LEN),
  .PAY_W     (AUD_W + TEL_W + CTL_W)
) u_sfg_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_i        (en_i),
  .aud_vld_i   (aud_vld_i),
  .tel_vld_i   (tel_vld_i),
  .ctl_vld_i   (ctl_vld_i),
  .fsync_o     (fsync_o),
  .txd_o       (txd_o),
  .frm_start_o (frm_start_o),
  .aud_pop_o   (aud_pop_o),
  .tel_pop_o   (tel_pop_o),
  .ctl_pop_o   (ctl_pop_o)
);

// File: tb/sframe_gen_bench.sv
module sframe_gen_bench;
  localparam int CLK_P = 10;
  localparam int FLEN  = 128;

  logic        clk = 1'b0;
  logic        rst_n, en;
  logic [15:0] aud, tel;
  logic [31:0] ctl;
  logic        av, tv, cv;
  logic        fsync, txd, fstart, apop, tpop, cpop;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int           k;
  logic [127:0] saved;

  always #(CLK_P/2) clk = ~clk;

  sframe_gen u_sframe_gen (
    .clk(clk), .rst_n(rst_n), .en_i(en),
    .aud_word_i(aud), .tel_word_i(tel), .ctl_word_i(ctl),
    .aud_vld_i(av), .tel_vld_i(tv), .ctl_vld_i(cv),
    .fsync_o(fsync), .txd_o(txd), .frm_start_o(fstart),
    .aud_pop_o(apop), .tel_pop_o(tpop), .ctl_pop_o(cpop)
  );

  function automatic logic [127:0] frame_img(logic [15:0] a, logic [15:0] t, logic [31:0] c,
                                             logic va, logic vt, logic vc);
    return {va ? a : 16'h0, vt ? t : 16'h0, vc ? c : 32'h0, 64'h0};
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b (k=%0d)", tag, what, act, exp, k);
    end
  endtask

  task automatic step(logic r, logic e, logic [15:0] a, logic [15:0] t, logic [31:0] c,
                      logic va, logic vt, logic vc);
    logic xfs, xst, xtx;
    int   pos;
    @(negedge clk);
    rst_n = r; en = e; aud = a; tel = t; ctl = c; av = va; tv = vt; cv = vc;
    #1;
    if (!r) begin
      chk("R9", "fsync", fsync, 1'b0);
      chk("R9", "txd", txd, 1'b0);
      chk("R9", "start", fstart, 1'b0);
      chk("R9", "pops", apop | tpop | cpop, 1'b0);
      k = 0; saved = '0;
    end else if (!e) begin
      chk("R8", "fsync", fsync, 1'b0);
      chk("R8", "txd", txd, 1'b0);
      chk("R8", "start", fstart, 1'b0);
      chk("R8", "pops", apop | tpop | cpop, 1'b0);
      k = 0; saved = '0;
    end else begin
      pos = k % FLEN;
      xfs = (pos == FLEN-1);
      xst = (k >= FLEN) && (pos == 0);
      xtx = (k >= FLEN) ? saved[127-pos] : 1'b0;
      chk("R1", "fsync", fsync, xfs);
      chk("R7", "start", fstart, xst);
      if (pos >= 64 || k < FLEN) chk("R4", "txd pad", txd, xtx);
      else                       chk("R3", "txd data", txd, xtx);
      chk(va ? "R6" : "R5", "aud_pop", apop, xfs & va);
      chk(vt ? "R6" : "R5", "tel_pop", tpop, xfs & vt);
      chk(vc ? "R6" : "R5", "ctl_pop", cpop, xfs & vc);
      if (xfs) saved = frame_img(a, t, c, va, vt, vc);
      k++;
    end
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; aud = '0; tel = '0; ctl = '0; av = 0; tv = 0; cv = 0;
    k = 0; saved = '0;
    void'($urandom(32'd20240611));
    // R9: reset held, then released with enable low
    for (int i = 0; i < 4; i++) step(0, 0, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 1, 1, 1);
    for (int i = 0; i < 5; i++) step(1, 0, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 1, 1, 1);
    // R3 R1 R2: full queues with fixed patterns over several frames
    for (int i = 0; i < 3*FLEN + 5; i++) step(1, 1, 16'hA5C3, 16'h8001, 32'hF00F_1234, 1, 1, 1);
    // R5: empty queues with nonzero words
    for (int i = 0; i < 2*FLEN; i++) step(1, 1, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 0, 0, 0);
    // R8: drop enable in the middle of a frame, then restart
    for (int i = 0; i < FLEN + 40; i++) step(1, 1, 16'h1357, 16'h2468, 32'hDEAD_BEEF, 1, 0, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF, 1, 1, 1);
    for (int i = 0; i < 2*FLEN + 10; i++) step(1, 1, 16'h0F0F, 16'hF0F0, 32'h8000_0001, 1, 1, 0);
    // random mix, rare enable drops
    for (int i = 0; i < 6000; i++) begin
      logic e;
      e = ($urandom % 600) != 0;
      step(1, e, 16'($urandom), 16'($urandom), $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule